// File: doc/BRIEF.md
# SPI Slave Message Transfer Interface

This block sits on the slave side of a four-wire SPI link and lets a remote master swap variable-length messages with a local processor. Both directions run in the same transfer. Each side first sends a one-byte status, then a one-byte word count, then that many 32-bit words. A side that has nothing to send gives a count of zero. Once its own words are done, a side sends zero bits for as long as the master keeps clocking.

On the local side there is a transmit word buffer that the processor fills and a receive word buffer that the processor empties. The slave raises an interrupt line while it holds queued words and the link is idle. This tells the master to run a transfer. At the end of each transfer, one-cycle pulses report whether the announced words were all sent, whether all the master's words were stored, and whether any incoming word was dropped.

The link pins are oversampled by the local clock. Every decision is therefore made in one clock domain, and the SPI clock must be well below the local clock.

Top module: `ipx_msg_slave`

## Requirements
- R1: The first byte the slave sends is a status byte. Bit 0 is 1 when the transmit buffer held at least one word at the moment select was asserted. Bit 1 is 1 when the receive buffer was empty at that moment. Bits 7 to 2 are 0.
- R2: After the status byte, the slave sends a length byte equal to the number of words queued when select was asserted. It then sends those words as 32-bit values in the order they were pushed.
- R3: For every bit the master clocks after the slave's announced words are done, the slave sends 0.
- R4: Bits travel MSB first in SPI mode 0. The slave samples ipDi on a rising ipClk and changes ipDo after a falling ipClk. The first status bit is on ipDo before the first rising edge.
- R5: The slave ignores the master's status byte. It takes the master's length byte as a word count and stores that many following words in the receive buffer in arrival order. Any further words in the same transfer are ignored and produce no overflow.
- R6: An announced incoming word is discarded in two cases: the receive buffer was not empty when select was asserted, or the buffer is full when the word completes. A discarded word leaves the buffer contents unchanged and causes an rxOvf pulse when the transfer ends.
- R7: ipInt is high while select is deasserted and the transmit buffer is non-empty. It falls within 3 clock cycles after select is asserted and stays low while select remains asserted.
- R8: ipDo is high impedance within 3 clock cycles after select is deasserted, and stays so while select is deasserted.
- R9: A transmit word leaves the buffer only after all 32 of its bits have been clocked. If a transfer ends early, the unsent words stay queued and are sent by the next transfer.
- R10: When select is deasserted, the block gives one-cycle pulses. txDone fires if a non-zero announced count was fully sent. rxDone fires if a non-zero master count was fully received with no word discarded.
- R11: txFull is high when the transmit buffer holds TX_DEPTH words. A push while txFull is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, also used to oversample the link pins |
| rstN | input | 1 | Active-low asynchronous reset |
| ipClk | input | 1 | SPI clock from the master |
| ipSelN | input | 1 | Active-low select from the master |
| ipDi | input | 1 | Serial data from the master |
| ipDo | output | 1 | Serial data to the master, high impedance while deselected |
| ipInt | output | 1 | Transfer request to the master |
| txPush | input | 1 | Pushes txWord into the transmit buffer |
| txWord | input | WORD_W | Word to queue for sending |
| txFull | output | 1 | Transmit buffer full |
| rxPop | input | 1 | Removes the head of the receive buffer |
| rxWord | output | WORD_W | Head of the receive buffer |
| rxAvail | output | 1 | Receive buffer holds at least one word |
| txDone | output | 1 | Pulse: the announced words were all sent |
| rxDone | output | 1 | Pulse: the master's words were all stored |
| rxOvf | output | 1 | Pulse: at least one incoming word was discarded |

## Verification
The assertions assume the following about the inputs:
- Each ipClk phase lasts several local clock cycles longer than the synchronizer latency.
- Select only changes while ipClk is low.
- ipDi is stable around each rising edge.
- The local side does not pop the receive buffer while a transfer is running.

The bench meets these assumptions by driving the link with eight-cycle half periods. It changes ipDi only together with the falling edge, and it performs every local push and pop between transfers.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  localparam int HDR_BITS = 16;
  localparam int LEN_W    = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_WORDS} phase_e;

  typedef struct packed {
    logic loadHdr;
    logic txShift;
    logic txLoadWord;
    logic txLoadZero;
    logic rxShift;
    logic rxPush;
    logic txPop;
  } strobe_t;
endpackage

// File: rtl/ipx_sync.sv
module ipx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ipx_fifo.sv
module ipx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ipx_ctrl.sv
module ipx_ctrl import ipx_pkg::*; #(
  parameter int TX_CW = 3,
  parameter int WORD_W = 32,
  localparam int BW = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkRise,
  input  logic               sclkFall,
  input  logic               selStart,
  input  logic               selEnd,
  input  logic               selActive,
  input  logic [TX_CW-1:0]   txCount,
  input  logic               rxEmpty,
  input  logic               rxFull,
  input  logic [LEN_W-1:0]   rxLenByte,
  output strobe_t            stb,
  output logic [HDR_BITS-1:0] hdrWord,
  output logic               txDone,
  output logic               rxDone,
  output logic               rxOvf,
  output logic               ipInt
);
  localparam logic [BW-1:0] HDR_LAST  = BW'(HDR_BITS - 1);
  localparam logic [BW-1:0] WORD_LAST = BW'(WORD_W - 1);

  phase_e           phase;
  logic [BW-1:0]    bitCnt;
  logic [LEN_W-1:0] wordIdx, txLen, rxLen;
  logic             rxLenValid, rxAccept, dropped;
  logic [LEN_W-1:0] txCnt8;
  logic [7:0]       statusByte;
  logic             busy, hdrLast, wordLast, riseOk, fallOk, dropNow;

  assign txCnt8     = LEN_W'(txCount);
  assign statusByte = {6'b0, rxEmpty, txCount != '0};
  assign hdrWord    = {statusByte, txCnt8};
  assign busy       = (phase != PH_IDLE);
  assign hdrLast    = (phase == PH_HDR) && (bitCnt == HDR_LAST);
  assign wordLast   = (phase == PH_WORDS) && (bitCnt == WORD_LAST);
  assign riseOk     = busy && sclkRise && !selEnd;
  assign fallOk     = busy && sclkFall && !selEnd;
  assign dropNow    = riseOk && wordLast && (wordIdx < rxLen) && !(rxAccept && !rxFull);

  always_comb begin
    stb = '0;
    if (selStart) stb.loadHdr = 1'b1;
    if (riseOk) begin
      stb.rxShift = 1'b1;
      if (wordLast) begin
        if (wordIdx < rxLen) stb.rxPush = rxAccept && !rxFull;
        if (wordIdx < txLen) stb.txPop = 1'b1;
      end
    end
    if (fallOk) begin
      if (phase == PH_WORDS && bitCnt == '0) begin
        if (wordIdx < txLen) stb.txLoadWord = 1'b1;
        else                 stb.txLoadZero = 1'b1;
      end else begin
        stb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      wordIdx    <= '0;
      txLen      <= '0;
      rxLen      <= '0;
      rxLenValid <= 1'b0;
      rxAccept   <= 1'b0;
      dropped    <= 1'b0;
      txDone     <= 1'b0;
      rxDone     <= 1'b0;
      rxOvf      <= 1'b0;
      ipInt      <= 1'b0;
    end else begin
      txDone <= 1'b0;
      rxDone <= 1'b0;
      rxOvf  <= 1'b0;
      ipInt  <= !selActive && (txCount != '0);
      if (selEnd) begin
        phase  <= PH_IDLE;
        txDone <= (txLen != '0) && (wordIdx >= txLen);
        rxDone <= rxLenValid && (rxLen != '0) && (wordIdx >= rxLen) && !dropped;
        rxOvf  <= dropped;
      end else if (selStart) begin
        phase      <= PH_HDR;
        bitCnt     <= '0;
        wordIdx    <= '0;
        txLen      <= txCnt8;
        rxLen      <= '0;
        rxLenValid <= 1'b0;
        rxAccept   <= rxEmpty;
        dropped    <= 1'b0;
      end else if (riseOk) begin
        if (hdrLast) begin
          phase      <= PH_WORDS;
          bitCnt     <= '0;
          rxLen      <= rxLenByte;
          rxLenValid <= 1'b1;
        end else if (wordLast) begin
          bitCnt <= '0;
          if (wordIdx != '1) wordIdx <= wordIdx + 1'b1;
          if (dropNow) dropped <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R7: the request line stays quiet while the master holds select
  p_int_low_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    selActive |=> !ipInt);

  // R10: completion indications last exactly one cycle
  p_txdone_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);
  p_rxdone_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
endmodule

// File: rtl/ipx_datapath.sv
module ipx_datapath import ipx_pkg::*; #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int WORD_W = 32,
  localparam int TX_CW = $clog2(TX_DEPTH + 1),
  localparam int RX_CW = $clog2(RX_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [HDR_BITS-1:0] hdrWord,
  input  logic                mosiS,
  input  logic                txPush,
  input  logic [WORD_W-1:0]   txWord,
  input  logic                rxPop,
  output logic                misoBit,
  output logic [TX_CW-1:0]    txCount,
  output logic                txFull,
  output logic                rxEmpty,
  output logic                rxFull,
  output logic [WORD_W-1:0]   rxHead,
  output logic [LEN_W-1:0]    rxLenByte
);
  logic [WORD_W-1:0] txHead, txShiftReg, rxShiftReg, rxNext;
  logic [RX_CW-1:0]  rxCount;

  ipx_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) txBuf (
    .clk(clk), .rstN(rstN), .push(txPush), .pop(stb.txPop), .din(txWord),
    .head(txHead), .count(txCount), .full(txFull));

  ipx_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) rxBuf (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(rxPop), .din(rxNext),
    .head(rxHead), .count(rxCount), .full(rxFull));

  assign rxEmpty   = (rxCount == '0);
  assign rxNext    = {rxShiftReg[WORD_W-2:0], mosiS};
  assign rxLenByte = rxNext[LEN_W-1:0];
  assign misoBit   = txShiftReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftReg <= '0;
      rxShiftReg <= '0;
    end else begin
      if (stb.loadHdr)         txShiftReg <= {hdrWord, {(WORD_W-HDR_BITS){1'b0}}};
      else if (stb.txLoadWord) txShiftReg <= txHead;
      else if (stb.txLoadZero) txShiftReg <= '0;
      else if (stb.txShift)    txShiftReg <= {txShiftReg[WORD_W-2:0], 1'b0};
      if (stb.rxShift) rxShiftReg <= rxNext;
    end
  end

  // R9: words are only taken from or retired out of a non-empty queue
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPop |-> txCount != '0);
  p_load_nonempty_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoadWord |-> txCount != '0);
  // R6: the control never stores into a full receive buffer
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPush |-> !rxFull);
endmodule

// File: rtl/ipx_msg_slave.sv
module ipx_msg_slave import ipx_pkg::*; #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int WORD_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ipClk,
  input  logic              ipSelN,
  input  logic              ipDi,
  output logic              ipDo,
  output logic              ipInt,
  input  logic              txPush,
  input  logic [WORD_W-1:0] txWord,
  output logic              txFull,
  input  logic              rxPop,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxAvail,
  output logic              txDone,
  output logic              rxDone,
  output logic              rxOvf
);
  logic [2:0] pinSync;
  logic selS, sclkS, mosiS, selPrev, sclkPrev;
  logic sclkRise, sclkFall, selStart, selEnd, selActive;
  strobe_t stb;
  logic [HDR_BITS-1:0] hdrWord;
  logic [TX_CW-1:0] txCount;
  logic rxEmpty, rxFull, misoBit;
  logic [LEN_W-1:0] rxLenByte;

  ipx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) pinSyncU (
    .clk(clk), .rstN(rstN), .din({ipSelN, ipClk, ipDi}), .dout(pinSync));

  assign selS  = pinSync[2];
  assign sclkS = pinSync[1];
  assign mosiS = pinSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selPrev  <= selS;
      sclkPrev <= sclkS;
    end
  end

  assign sclkRise  = sclkS && !sclkPrev;
  assign sclkFall  = !sclkS && sclkPrev;
  assign selStart  = !selS && selPrev;
  assign selEnd    = selS && !selPrev;
  assign selActive = !selS;

  ipx_ctrl #(.TX_CW(TX_CW), .WORD_W(WORD_W)) ctrlU (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .selStart(selStart), .selEnd(selEnd), .selActive(selActive),
    .txCount(txCount), .rxEmpty(rxEmpty), .rxFull(rxFull), .rxLenByte(rxLenByte),
    .stb(stb), .hdrWord(hdrWord), .txDone(txDone), .rxDone(rxDone),
    .rxOvf(rxOvf), .ipInt(ipInt));

  ipx_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .WORD_W(WORD_W)) dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .hdrWord(hdrWord), .mosiS(mosiS),
    .txPush(txPush), .txWord(txWord), .rxPop(rxPop), .misoBit(misoBit),
    .txCount(txCount), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .rxHead(rxWord), .rxLenByte(rxLenByte));

  assign rxAvail = !rxEmpty;
  assign ipDo    = selActive ? misoBit : 1'bz;
endmodule

// File: tb/ipx_msg_slave_test.sv
module ipx_msg_slave_test;
  localparam int TXD = 4;
  localparam int RXD = 4;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, ipClk = 1'b0, ipSelN = 1'b1, ipDi = 1'b0;
  logic txPush = 1'b0, rxPop = 1'b0;
  logic [31:0] txWord = '0;
  wire doNet;
  pullup (doNet);
  logic ipInt, txFull, rxAvail, txDone, rxDone, rxOvf;
  logic [31:0] rxWord;

  int nChk = 0, nBad = 0, nTxDone = 0, nRxDone = 0, nOvf = 0;
  bit finished = 1'b0;
  logic [31:0] mTx[$], mRx[$], masterOut[$];

  always #4 clk = ~clk;

  ipx_msg_slave uut (
    .clk(clk), .rstN(rstN), .ipClk(ipClk), .ipSelN(ipSelN), .ipDi(ipDi),
    .ipDo(doNet), .ipInt(ipInt), .txPush(txPush), .txWord(txWord),
    .txFull(txFull), .rxPop(rxPop), .rxWord(rxWord), .rxAvail(rxAvail),
    .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf));

  always @(negedge clk) begin
    if (txDone) nTxDone++;
    if (rxDone) nRxDone++;
    if (rxOvf)  nOvf++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pushWord(input logic [31:0] w);
    bit wasFull = (mTx.size() >= TXD);
    check(txFull == wasFull, "R11", "txFull before push", 32'(txFull), 32'(wasFull));
    @(negedge clk); txPush = 1'b1; txWord = w;
    @(negedge clk); txPush = 1'b0;
    if (!wasFull) mTx.push_back(w);
  endtask

  task automatic drainRx(input string req);
    while (mRx.size() > 0) begin
      check(rxAvail == 1'b1, req, "rxAvail", 32'(rxAvail), 32'd1);
      check(rxWord == mRx[0], req, "rxWord", rxWord, mRx[0]);
      @(negedge clk); rxPop = 1'b1;
      @(negedge clk); rxPop = 1'b0;
      void'(mRx.pop_front());
    end
    check(rxAvail == 1'b0, req, "rxAvail after drain", 32'(rxAvail), 32'd0);
  endtask

  task automatic xfer(input int mLen, input int nW);
    logic [7:0] expStat;
    int expLen, sent, stored, t0, r0, o0;
    bit rxOk, discard;
    bit mo[$];
    logic [31:0] gotW[$], expW[$];
    logic [31:0] sh = '0, w;
    logic [7:0] gotStat = '0, gotLen = '0;
    bit expTxDone, expRxDone;

    expStat = {6'b0, mRx.size() == 0, mTx.size() != 0};
    expLen  = mTx.size();
    rxOk    = (mRx.size() == 0);
    for (int i = 0; i < nW; i++) expW.push_back((i < expLen) ? mTx[i] : 32'h0);
    for (int b = 7; b >= 0; b--) mo.push_back(bit'(8'hA5 >> b));
    for (int b = 7; b >= 0; b--) mo.push_back(bit'(8'(mLen) >> b));
    for (int i = 0; i < nW; i++) begin
      w = (i < masterOut.size()) ? masterOut[i] : 32'h0;
      for (int b = 31; b >= 0; b--) mo.push_back(w[b]);
    end
    t0 = nTxDone; r0 = nRxDone; o0 = nOvf;

    @(negedge clk); ipSelN = 1'b0;
    for (int k = 0; k < mo.size(); k++) begin
      ipDi = mo[k];
      if (k == 0) begin
        repeat (6) @(negedge clk);
        check(ipInt == 1'b0, "R7", "ipInt while selected", 32'(ipInt), 32'd0);
        repeat (HALF - 6) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sh = {sh[30:0], doNet};
      ipClk = 1'b1;
      repeat (HALF) @(negedge clk);
      ipClk = 1'b0;
      if (k == 7)  gotStat = sh[7:0];
      if (k == 15) gotLen  = sh[7:0];
      if (k >= 16 && ((k - 15) % 32) == 0) gotW.push_back(sh);
    end
    repeat (HALF) @(negedge clk);
    ipSelN = 1'b1; ipDi = 1'b0;
    repeat (6) @(negedge clk);
    check(doNet === 1'b1, "R8", "ipDo released after deselect", 32'(doNet), 32'd1);
    repeat (6) @(negedge clk);

    check(gotStat == expStat, "R1 R4", "status byte", 32'(gotStat), 32'(expStat));
    check(gotLen == 8'(expLen), "R2", "length byte", 32'(gotLen), 32'(expLen));
    for (int i = 0; i < nW; i++)
      check(gotW[i] == expW[i], (i < expLen) ? "R2" : "R3", "slave word", gotW[i], expW[i]);

    sent = (nW < expLen) ? nW : expLen;
    for (int i = 0; i < sent; i++) void'(mTx.pop_front());
    discard = 1'b0;
    stored = (nW < mLen) ? nW : mLen;
    for (int i = 0; i < stored; i++) begin
      if (rxOk && mRx.size() < RXD) mRx.push_back(masterOut[i]);
      else discard = 1'b1;
    end
    expTxDone = (expLen > 0) && (nW >= expLen);
    expRxDone = (mLen > 0) && (nW >= mLen) && !discard;
    check((nTxDone - t0) == int'(expTxDone), "R10", "txDone pulses", 32'(nTxDone - t0), 32'(expTxDone));
    check((nRxDone - r0) == int'(expRxDone), "R10", "rxDone pulses", 32'(nRxDone - r0), 32'(expRxDone));
    check((nOvf - o0) == int'(discard), "R6", "rxOvf pulses", 32'(nOvf - o0), 32'(discard));
    masterOut.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL R4 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(ipInt == 1'b0, "R7", "reset ipInt", 32'(ipInt), 32'd0);
    check(doNet === 1'b1, "R8", "reset ipDo released", 32'(doNet), 32'd1);
    check(rxAvail == 1'b0, "R5", "reset rxAvail", 32'(rxAvail), 32'd0);
    check(txFull == 1'b0, "R11", "reset txFull", 32'(txFull), 32'd0);

    // slave-only message
    pushWord(32'hA1B2C3D4); pushWord(32'h1234567A);
    repeat (3) @(negedge clk);
    check(ipInt == 1'b1, "R7", "request with queued words", 32'(ipInt), 32'd1);
    xfer(0, 2);
    repeat (3) @(negedge clk);
    check(ipInt == 1'b0, "R7", "request after queue drained", 32'(ipInt), 32'd0);

    // master-only message, kept in the buffer
    masterOut = '{32'hB0000001, 32'hB0000002, 32'hB0000003};
    xfer(3, 3);
    // receive buffer not empty: words discarded
    masterOut = '{32'hC0C0C0C0, 32'hC1C1C1C1};
    xfer(2, 2);
    drainRx("R6");

    // both directions, slave shorter: zero fill
    pushWord(32'hD0000010); pushWord(32'hD0000020); pushWord(32'hD0000030);
    masterOut = '{32'hE1, 32'hE2, 32'hE3, 32'hE4};
    xfer(4, 4);
    drainRx("R5");

    // early end keeps unsent words
    pushWord(32'hF1F1F1F0); pushWord(32'hF2F2F2F0); pushWord(32'hF3F3F3F0);
    xfer(0, 1);
    repeat (3) @(negedge clk);
    check(ipInt == 1'b1, "R9", "request after early end", 32'(ipInt), 32'd1);
    xfer(0, 2);

    // push into a full queue is ignored
    pushWord(32'h61); pushWord(32'h62); pushWord(32'h63); pushWord(32'h64);
    pushWord(32'h65);
    repeat (2) @(negedge clk);
    check(txFull == 1'b1, "R11", "txFull at depth", 32'(txFull), 32'd1);
    xfer(0, 5);

    // more words than the receive buffer holds
    masterOut = '{32'h71, 32'h72, 32'h73, 32'h74, 32'h75, 32'h76};
    xfer(6, 6);
    drainRx("R6");

    // words past the master's length are ignored
    masterOut = '{32'h81, 32'h82, 32'h83};
    xfer(1, 3);
    drainRx("R5");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule